// File: doc/BRIEF.md
# Stereo Soft Power Ramp Controller

This block shapes the level of a stereo sample stream while an audio output path is powered up or powered down, so the signal that reaches the converter never jumps. A level-sensitive request input says which state is wanted. While it is high the block walks a position counter upward, one step per input sample strobe. While it is low the counter walks downward. The gain applied to both channels is a fixed function of that position.

Over the first 128 positions the gain follows a raised-cosine curve from zero to one half. It is read from a table that is computed when the design is built. Over the next 512 positions the gain rises linearly from one half to unity. A complete transition therefore takes 640 sample periods, about 14.5 ms at 44.1 kHz. Power-down retraces the same curve backwards, so the linear part comes first and the cosine part second. When the request flips in the middle of a transition, the walk simply turns around at the current position.

Each strobed sample is multiplied by the gain in force at that strobe. The product is rounded and clipped back to the sample width, and it appears on the outputs one clock later. The outputs then hold their value until the next strobe.

Top module: `soft_ramp_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, both outputs are zero, `done` is low, and the position is zero (fully powered down), so `busy` follows `pwr_req`.
- R2: The position changes only on a clock edge where `smp_stb` is high. A request change without a strobe leaves the gain untouched.
- R3: For position p in 0..127 the gain is round(8192*(1-cos(pi*p/128))). The gain is an unsigned value in which unity is 32768.
- R4: For position p in 128..640 the gain is 16384 + 32*(p-128), reaching exactly 32768 at p = 640.
- R5: From position 0 with `pwr_req` high, the 640th strobe brings the position to 640. `done` is high for exactly one clock, in the cycle after that strobe.
- R6: With `pwr_req` low, each strobe lowers the position by one, retracing the linear segment first and then the cosine segment. `done` pulses after the 640th strobe from full level, when position 0 is reached.
- R7: When `pwr_req` flips during a transition, the position continues from its current value in the new direction, with no restart.
- R8: `busy` is high exactly when the position differs from the endpoint selected by `pwr_req`: 640 when it is high, 0 when it is low.
- R9: Each output equals floor((sample*gain + 16384) / 32768), which rounds a half upward. The result is clipped to the signed sample range, so -32768 and 32767 pass unchanged at unity.
- R10: The outputs update one clock after a strobe, from the sample and the gain at that strobe, and hold between strobes.
- R11: A strobe while the position already sits at the requested endpoint leaves the position unchanged and does not pulse `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-clock strobe marking a new input sample |
| pwr_req | input | 1 | 1 = ramp toward full level, 0 = ramp toward silence |
| in_l | input | 16 | Signed left sample |
| in_r | input | 16 | Signed right sample |
| out_l | output | 16 | Gain-scaled signed left sample |
| out_r | output | 16 | Gain-scaled signed right sample |
| busy | output | 1 | Position differs from the requested endpoint |
| done | output | 1 | One-clock pulse when an endpoint is reached |

## Verification
Every result of a strobe is due exactly one clock after the edge that sampled it: the scaled outputs, the `done` pulse and the new position. `busy` follows the registered position and the request with no extra delay. The bench raises the strobe at a falling edge and drops it at the next one, then reads outputs, `done` and `busy` at that second falling edge. One clock later it reads them again to confirm the pulse has ended and the outputs are held. Expected gains come from a bench-side model of the position and the curve formulas. The model advances on the same strobes as the design.

// File: rtl/soft_ramp_pkg.sv
package soft_ramp_pkg;
  localparam int SMP_W_DEF   = 16;
  localparam int GAIN_W_DEF  = 16;
  localparam int CURVE_N_DEF = 128;
  localparam int LINE_N_DEF  = 512;

  function automatic int unsigned rc_point(input int idx, input int len, input int half);
    real ph;
    ph = 3.14159265358979 * real'(idx) / real'(len);
    return $rtoi(real'(half) * (1.0 - $cos(ph)) / 2.0 + 0.5);
  endfunction
endpackage

// File: rtl/rc_rom.sv
module rc_rom
  import soft_ramp_pkg::*;
#(
  parameter int GAIN_W  = GAIN_W_DEF,
  parameter int CURVE_N = CURVE_N_DEF
) (
  input  logic [$clog2(CURVE_N)-1:0] idx,
  output logic [GAIN_W-1:0]          val
);
  localparam int HALF = 1 << (GAIN_W - 2);

  logic [GAIN_W-1:0] tbl [CURVE_N];

  for (genvar k = 0; k < CURVE_N; k++) begin : g_ent
    localparam int unsigned ENT = rc_point(k, CURVE_N, HALF);
    assign tbl[k] = GAIN_W'(ENT);
  end

  assign val = tbl[idx];
endmodule

// File: rtl/gain_map.sv
module gain_map
  import soft_ramp_pkg::*;
#(
  parameter int GAIN_W  = GAIN_W_DEF,
  parameter int CURVE_N = CURVE_N_DEF,
  parameter int LINE_N  = LINE_N_DEF,
  parameter int POS_W   = $clog2(CURVE_N + LINE_N + 1)
) (
  input  logic [POS_W-1:0]  pos,
  output logic [GAIN_W-1:0] gain
);
  localparam int IDX_W = $clog2(CURVE_N);
  localparam int HALF  = 1 << (GAIN_W - 2);
  localparam int MW    = POS_W + GAIN_W;

  logic [GAIN_W-1:0] curve_g;
  logic [MW-1:0]     line_off;

  rc_rom #(.GAIN_W(GAIN_W), .CURVE_N(CURVE_N)) u_rom (
    .idx (pos[IDX_W-1:0]),
    .val (curve_g)
  );

  always_comb begin
    line_off = (MW'(pos - POS_W'(CURVE_N)) * MW'(HALF)) / MW'(LINE_N);
    if (pos < POS_W'(CURVE_N)) gain = curve_g;
    else                       gain = GAIN_W'(MW'(HALF) + line_off);
  end
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq #(
  parameter int TOTAL = 640,
  parameter int POS_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             req,
  output logic [POS_W-1:0] pos,
  output logic             busy,
  output logic             done
);
  localparam logic [POS_W-1:0] TOP = POS_W'(TOTAL);

  logic [POS_W-1:0] pos_d;
  logic             done_d;

  always_comb begin
    pos_d  = pos;
    done_d = 1'b0;
    if (stb) begin
      if (req && pos != TOP) begin
        pos_d  = pos + 1'b1;
        done_d = (pos == TOP - 1'b1);
      end else if (!req && pos != '0) begin
        pos_d  = pos - 1'b1;
        done_d = (pos == POS_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos <= '0;
    else if (stb) pos <= pos_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= done_d;
  end

  assign busy = req ? (pos != TOP) : (pos != '0);
endmodule

// File: rtl/chan_scale.sv
module chan_scale
  import soft_ramp_pkg::*;
#(
  parameter int SMP_W  = SMP_W_DEF,
  parameter int GAIN_W = GAIN_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [SMP_W-1:0] din,
  input  logic [GAIN_W-1:0]       gain,
  output logic signed [SMP_W-1:0] dout
);
  localparam int PW = SMP_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (SMP_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (SMP_W - 1));
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (GAIN_W - 2);

  logic signed [PW-1:0]    a_ext, g_ext, prod, shf;
  logic signed [SMP_W-1:0] dout_d;

  always_comb begin
    a_ext = PW'(din);
    g_ext = $signed(PW'({1'b0, gain}));
    prod  = a_ext * g_ext;
    shf   = (prod + RND) >>> (GAIN_W - 1);
    if (shf > MAXV)      dout_d = MAXV[SMP_W-1:0];
    else if (shf < MINV) dout_d = MINV[SMP_W-1:0];
    else                 dout_d = shf[SMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dout <= '0;
    else if (en) dout <= dout_d;
  end
endmodule

// File: rtl/soft_ramp_ctrl.sv
module soft_ramp_ctrl
  import soft_ramp_pkg::*;
#(
  parameter int SMP_W   = SMP_W_DEF,
  parameter int GAIN_W  = GAIN_W_DEF,
  parameter int CURVE_N = CURVE_N_DEF,
  parameter int LINE_N  = LINE_N_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic                    pwr_req,
  input  logic signed [SMP_W-1:0] in_l,
  input  logic signed [SMP_W-1:0] in_r,
  output logic signed [SMP_W-1:0] out_l,
  output logic signed [SMP_W-1:0] out_r,
  output logic                    busy,
  output logic                    done
);
  localparam int TOTAL = CURVE_N + LINE_N;
  localparam int POS_W = $clog2(TOTAL + 1);

  logic                    rst_m, rst_sync_n;
  logic [POS_W-1:0]        pos_q;
  logic [GAIN_W-1:0]       gain_w;
  logic signed [SMP_W-1:0] ch_in  [2];
  logic signed [SMP_W-1:0] ch_out [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_sync_n <= rst_m;
    end
  end

  ramp_seq #(.TOTAL(TOTAL), .POS_W(POS_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .stb   (smp_stb),
    .req   (pwr_req),
    .pos   (pos_q),
    .busy  (busy),
    .done  (done)
  );

  gain_map #(.GAIN_W(GAIN_W), .CURVE_N(CURVE_N), .LINE_N(LINE_N), .POS_W(POS_W)) u_map (
    .pos  (pos_q),
    .gain (gain_w)
  );

  assign ch_in[0] = in_l;
  assign ch_in[1] = in_r;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    chan_scale #(.SMP_W(SMP_W), .GAIN_W(GAIN_W)) u_scale (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (smp_stb),
      .din   (ch_in[c]),
      .gain  (gain_w),
      .dout  (ch_out[c])
    );
  end

  assign out_l = ch_out[0];
  assign out_r = ch_out[1];
endmodule

// File: rtl/soft_ramp_chk.sv
module soft_ramp_chk #(
  parameter int SMP_W  = 16,
  parameter int GAIN_W = 16,
  parameter int POS_W  = 10,
  parameter int TOTAL  = 640
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_stb,
  input logic [POS_W-1:0]        pos,
  input logic [GAIN_W-1:0]       gain,
  input logic                    busy,
  input logic                    done,
  input logic signed [SMP_W-1:0] out_l,
  input logic signed [SMP_W-1:0] out_r
);
  localparam logic [POS_W-1:0]  TOP   = POS_W'(TOTAL);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W - 1);

  assert_pos_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(pos));

  assert_gain_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= UNITY);

  assert_pos_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= TOP);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pos == TOP || pos == '0));

  assert_unit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> (pos == $past(pos) || pos == $past(pos) + 1'b1 || pos + 1'b1 == $past(pos)));

  assert_idle_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pos == TOP || pos == '0));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(out_l) && $stable(out_r)));
endmodule

bind soft_ramp_ctrl soft_ramp_chk #(
  .SMP_W(SMP_W), .GAIN_W(GAIN_W), .POS_W(POS_W), .TOTAL(TOTAL)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .smp_stb (smp_stb),
  .pos     (pos_q),
  .gain    (gain_w),
  .busy    (busy),
  .done    (done),
  .out_l   (out_l),
  .out_r   (out_r)
);

// File: tb/test_soft_ramp_ctrl.sv
`timescale 1ns/1ps
module test_soft_ramp_ctrl;
  localparam int FULL = 640;
  localparam int NV   = 16;
  localparam logic signed [15:0] VEC_L [NV] = '{
    16'sd32767, -16'sd32768, 16'sd0, 16'sd1, -16'sd1, 16'sd12345, -16'sd20000, 16'sd2,
    -16'sd2, 16'sd30000, -16'sd7, 16'sd1000, -16'sd1000, 16'sd25000, 16'sd3, -16'sd32767};
  localparam logic signed [15:0] VEC_R [NV] = '{
    -16'sd32768, 16'sd32767, 16'sd5, -16'sd5, 16'sd16384, -16'sd16384, 16'sd777, 16'sd0,
    -16'sd9999, 16'sd8191, 16'sd1, -16'sd3, 16'sd20000, -16'sd25000, -16'sd2, 16'sd100};

  logic clk = 1'b0;
  logic rst_n, smp_stb, pwr_req;
  logic signed [15:0] in_l, in_r, out_l, out_r;
  logic busy, done;

  int n_chk  = 0;
  int n_fail = 0;
  int mpos   = 0;

  always #4 clk = ~clk;

  soft_ramp_ctrl i_soft_ramp_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .pwr_req(pwr_req),
    .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
    .busy(busy), .done(done)
  );

  function automatic int bgain(input int p);
    if (p < 128) return $rtoi(8192.0 * (1.0 - $cos(3.14159265358979 * real'(p) / 128.0)) + 0.5);
    return 16384 + 32 * (p - 128);
  endfunction

  function automatic int bscale(input int s, input int g);
    longint pr;
    pr = longint'(s) * longint'(g) + 64'sd16384;
    pr = pr >>> 15;
    if (pr > 32767)  pr = 32767;
    if (pr < -32768) pr = -32768;
    return int'(pr);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic signed [15:0] l, input logic signed [15:0] r, input string tag);
    int el, er, eb, ed, hl, hr;
    @(negedge clk);
    in_l = l; in_r = r; smp_stb = 1'b1;
    el = bscale(int'(l), bgain(mpos));
    er = bscale(int'(r), bgain(mpos));
    ed = 0;
    if (pwr_req && mpos < FULL) begin
      mpos++; ed = (mpos == FULL) ? 1 : 0;
    end else if (!pwr_req && mpos > 0) begin
      mpos--; ed = (mpos == 0) ? 1 : 0;
    end
    eb = pwr_req ? ((mpos != FULL) ? 1 : 0) : ((mpos != 0) ? 1 : 0);
    @(negedge clk);
    smp_stb = 1'b0;
    check({tag, " out_l"}, int'(out_l), el);
    check({tag, " out_r"}, int'(out_r), er);
    check({tag, " done R5"}, int'(done), ed);
    check({tag, " busy R8"}, int'(busy), eb);
    hl = int'(out_l); hr = int'(out_r);
    @(negedge clk);
    check("R5 done width", int'(done), 0);
    check("R10 hold", int'(out_l) + 65536 * int'(out_r), hl + 65536 * hr);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; smp_stb = 1'b0; pwr_req = 1'b0; in_l = '0; in_r = '0;
    repeat (3) @(negedge clk);
    check("R1 reset out_l", int'(out_l), 0);
    check("R1 reset out_r", int'(out_r), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: request raised, no strobe for a while; gain must still be at position 0
    pwr_req = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 busy after req", int'(busy), 1);
    strobe(16'sd32767, -16'sd32768, "R2 gated");

    // table walk: full power-up then idle strobes (R3, R4, R5, R11)
    for (int k = 1; k < FULL + 8; k++) begin
      if (mpos < 128) strobe(VEC_L[k % NV], VEC_R[k % NV], "R3 up");
      else if (mpos < FULL) strobe(VEC_L[k % NV], VEC_R[k % NV], "R4 up");
      else strobe(VEC_L[k % NV], VEC_R[k % NV], "R11 idle");
    end

    // R9: rounding and range at unity gain
    strobe(-16'sd32768, 16'sd32767, "R9 unity");
    strobe(16'sd1, -16'sd1, "R9 unity");

    // R6: full power-down then idle strobes
    pwr_req = 1'b0;
    for (int k = 0; k < FULL + 6; k++)
      strobe(VEC_L[(k + 3) % NV], VEC_R[(k + 5) % NV], "R6 down");

    // R7: reverse mid-transition in both segments
    pwr_req = 1'b1;
    for (int k = 0; k < 300; k++) strobe(VEC_L[k % NV], VEC_R[k % NV], "R7 up");
    pwr_req = 1'b0;
    for (int k = 0; k < 230; k++) strobe(VEC_L[k % NV], VEC_R[k % NV], "R7 down");
    pwr_req = 1'b1;
    for (int k = 0; k < 40; k++) strobe(VEC_L[k % NV], VEC_R[k % NV], "R7 up2");

    // R9: rounding of halves inside the cosine segment
    strobe(16'sd2, -16'sd2, "R9 half");
    strobe(-16'sd3, 16'sd3, "R9 half");

    // R1: reset mid-ramp returns to silence
    @(negedge clk);
    rst_n = 1'b0; pwr_req = 1'b0; mpos = 0;
    @(negedge clk);
    check("R1 midreset out_l", int'(out_l), 0);
    check("R1 midreset out_r", int'(out_r), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 midreset busy", int'(busy), 0);
    strobe(16'sd1000, 16'sd1000, "R1 after reset");

    finish_run();
  end
endmodule